// File: doc/BRIEF.md
# Multi-Client Stream Buffer Arbiter

This block sits between one wide, single-ported storage array and eighteen stream clients. Every client owns a 64-word circular buffer. On the client side a buffer is read or written one access per cycle. On the array side it is refilled or emptied in 32-word lines, so one array access moves half a buffer. A round-robin arbiter picks one requesting buffer per cycle for that single array access.

A client starts a stream with a one-cycle start pulse and a descriptor. The descriptor gives a direction, a base line in the array, a record count and a record size. The stream length in words is the record count times the record size.

Fill streams move data from the array to the client. A fill buffer asks for the array whenever at least 32 words of its buffer are free.

Drain streams move data from the client to the array. A drain buffer asks for the array when it holds a full line, or when the last, shorter piece of the stream is complete.

The first eight clients are the wide lane clients and move eight words per access. The remaining ten clients move one word per access. The array is modelled inside the block as a plain line memory.

Top module: `sbuf_hub`

## Requirements
- R1: A start pulse while the buffer is idle loads the descriptor: base line, record count (8 bits) and record size (4 bits). The stream length in words is count × size and must be a whole multiple of the client's access width: 8 words for clients 0–7, 1 word for clients 8–17. A non-zero length raises `busy_o` in the cycle after the start pulse.
- R2: Fill streams (direction 0) deliver array words in order, starting at word base×32, with consecutive lines following. Word k of an access (bits 16k+15:16k) is stream word index+k. `rvalid_o` is high whenever enough words are held for one access.
- R3: A buffer never holds more than 64 words. A stalled fill client loses or overwrites no data, however long it waits.
- R4: Drain streams (direction 1) accept words while `wready_o` is high. Stream word i lands at array word base×32+i.
- R5: When a drain stream ends partway through a line, only the stream's own words are written. The rest of that array line keeps its earlier contents.
- R6: At most one client is granted the array per cycle. Grants rotate round-robin, so when all clients request together, each is granted exactly once in the first 18 grants.
- R7: A pop while `rvalid_o` is low, or a push while `wready_o` is low, has no effect. No word is consumed and no word is stored.
- R8: A start whose direction differs from that of the running stream is rejected and raises `err_o` for exactly one cycle. A start with the same direction while busy is ignored without error. In both cases the running stream continues unchanged.
- R9: After reset, `busy_o`, `rvalid_o`, `wready_o`, `err_o` and `gnt_o` are all low. `busy_o` falls in the cycle after the final pop of a fill stream, and after the final array write of a drain stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 18 | Per-client stream start pulse |
| dir_i | input | 18 | Per-client direction: 0 = fill, 1 = drain |
| base_i | input | 18×6 | Per-client base line in the array |
| rec_cnt_i | input | 18×8 | Per-client record count |
| rec_size_i | input | 18×4 | Per-client record size in words |
| busy_o | output | 18 | Stream active |
| err_o | output | 18 | One-cycle pulse on a rejected direction change |
| push_i | input | 18 | Client write strobe |
| wdata_i | input | 8×128+10×16 | Client write data: 8 words per wide client, then 1 word per narrow client |
| wready_o | output | 18 | Room for one client write |
| pop_i | input | 18 | Client read strobe |
| rdata_o | output | 8×128+10×16 | Client read data, same packing as `wdata_i` |
| rvalid_o | output | 18 | Data held for one client read |
| gnt_o | output | 18 | Array grant of this cycle |

## Verification
The bench goes after the following corner cases.

- **Trailing short line.** A 40-word drain over a line already written is used. If the design ignored the word mask, the words past the stream end would be overwritten.
- **Long stall.** A 128-word fill is stalled for 60 cycles. If the design requested without enough room, the stalled words would be overwritten.
- **Pop before the first line arrives.** The pop is issued in the very cycle before the first line lands. A design that did not gate the pop would skip stream word zero.
- **Mid-stream restart.** A start with the opposite direction, and one with the same direction but a new base, are both issued mid-stream. A design that accepted either would send the data to the wrong line, or miss the error pulse.
- **Fairness.** All eighteen fills start in the same cycle. A fixed-priority or broken-pointer arbiter would grant some client twice within the first eighteen grants.

// File: rtl/sba_pkg.sv
package sba_pkg;
  typedef enum logic {
    DIR_FILL  = 1'b0,
    DIR_DRAIN = 1'b1
  } dir_e;
endpackage

// File: rtl/sba_rr_arb.sv
module sba_rr_arb #(
  parameter int unsigned N = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int unsigned IW = $clog2(N);

  logic [IW-1:0] last_q, pick;
  logic          any;

  always_comb begin
    gnt_o = '0;
    pick  = last_q;
    any   = 1'b0;
    for (int unsigned i = 1; i <= N; i++) begin
      automatic int unsigned k = (32'(last_q) + i) % N;
      if (!any && req_i[k]) begin
        any      = 1'b1;
        pick     = IW'(k);
        gnt_o[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= IW'(N - 1);
    else if (any) last_q <= pick;
  end

  p_onehot_gnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_work_conserving_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/sba_array.sv
module sba_array #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LINE_W = 32,
  parameter int unsigned LINES  = 64,
  parameter int unsigned AW     = 6
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [LINE_W*WORD_W-1:0] wdata_i,
  input  logic [LINE_W-1:0]        wmask_i,
  output logic [LINE_W*WORD_W-1:0] rdata_o
);
  logic [LINE_W*WORD_W-1:0] mem [LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int k = 0; k < LINE_W; k++) begin
        if (wmask_i[k]) mem[addr_i][k*WORD_W +: WORD_W] <= wdata_i[k*WORD_W +: WORD_W];
      end
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/sba_stream_buf.sv
module sba_stream_buf
  import sba_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned LINE_W = 32,
  parameter int unsigned CW     = 1,
  parameter int unsigned AW     = 6,
  parameter int unsigned LEN_W  = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     dir_i,
  input  logic [AW-1:0]            base_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic                     busy_o,
  output logic                     err_o,
  output logic                     req_o,
  input  logic                     gnt_i,
  output logic [AW-1:0]            line_o,
  output logic                     drain_o,
  output logic [LINE_W*WORD_W-1:0] bulk_wdata_o,
  output logic [LINE_W-1:0]        bulk_mask_o,
  input  logic [LINE_W*WORD_W-1:0] bulk_rdata_i,
  input  logic                     push_i,
  input  logic [CW*WORD_W-1:0]     wdata_i,
  output logic                     wready_o,
  input  logic                     pop_i,
  output logic [CW*WORD_W-1:0]     rdata_o,
  output logic                     rvalid_o
);
  localparam int unsigned PW    = $clog2(DEPTH);
  localparam int unsigned CNT_W = PW + 1;
  localparam logic [CNT_W-1:0] CW_C    = CNT_W'(CW);
  localparam logic [CNT_W-1:0] LINE_C  = CNT_W'(LINE_W);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic             active_q, err_q;
  dir_e             dir_q;
  logic [PW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q, cnt_n, free_w, xfer_n;
  logic [AW-1:0]    line_q;
  logic [LEN_W-1:0] bulk_q, cli_q, bulk_n, cli_n;
  logic             fill, do_pop, do_push, do_bulk;

  logic [WORD_W-1:0] mem [DEPTH];

  assign fill   = (dir_q == DIR_FILL);
  assign free_w = DEPTH_C - cnt_q;
  assign xfer_n = (bulk_q >= LEN_W'(LINE_W)) ? LINE_C : CNT_W'(bulk_q);

  assign rvalid_o = active_q && fill && (cnt_q >= CW_C) && (cli_q != '0);
  assign wready_o = active_q && !fill && (free_w >= CW_C) && (cli_q != '0);
  // drain side also flushes the final short piece once the client is done
  assign req_o    = active_q && (bulk_q != '0) &&
                    (fill ? (free_w >= LINE_C)
                          : ((cnt_q >= LINE_C) || (cli_q == '0 && cnt_q != '0)));

  assign do_pop  = pop_i && rvalid_o;
  assign do_push = push_i && wready_o;
  assign do_bulk = gnt_i && req_o;

  always_comb begin
    cnt_n = cnt_q;
    if (do_push) cnt_n = cnt_n + CW_C;
    if (do_pop)  cnt_n = cnt_n - CW_C;
    if (do_bulk) cnt_n = fill ? cnt_n + xfer_n : cnt_n - xfer_n;
    bulk_n = do_bulk ? bulk_q - LEN_W'(xfer_n) : bulk_q;
    cli_n  = (do_pop || do_push) ? cli_q - LEN_W'(CW) : cli_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      dir_q    <= DIR_FILL;
      wp_q     <= '0;
      rp_q     <= '0;
      cnt_q    <= '0;
      line_q   <= '0;
      bulk_q   <= '0;
      cli_q    <= '0;
    end else begin
      err_q <= 1'b0;
      if (start_i && !active_q) begin
        active_q <= (len_i != '0);
        dir_q    <= dir_e'(dir_i);
        wp_q     <= '0;
        rp_q     <= '0;
        cnt_q    <= '0;
        line_q   <= base_i;
        bulk_q   <= len_i;
        cli_q    <= len_i;
      end else begin
        if (start_i && (dir_e'(dir_i) != dir_q)) err_q <= 1'b1;
        if (active_q) begin
          cnt_q  <= cnt_n;
          bulk_q <= bulk_n;
          cli_q  <= cli_n;
          if (do_bulk) line_q <= line_q + 1'b1;
          if (fill) begin
            if (do_bulk) wp_q <= wp_q + PW'(LINE_W);
            if (do_pop)  rp_q <= rp_q + PW'(CW);
          end else begin
            if (do_push) wp_q <= wp_q + PW'(CW);
            if (do_bulk) rp_q <= rp_q + PW'(LINE_W);
          end
          active_q <= !(bulk_n == '0 && cli_n == '0);
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_bulk && fill) begin
      for (int k = 0; k < LINE_W; k++) mem[PW'(wp_q + PW'(k))] <= bulk_rdata_i[k*WORD_W +: WORD_W];
    end
    if (do_push) begin
      for (int k = 0; k < CW; k++) mem[PW'(wp_q + PW'(k))] <= wdata_i[k*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    for (int k = 0; k < CW; k++) rdata_o[k*WORD_W +: WORD_W] = mem[PW'(rp_q + PW'(k))];
    for (int k = 0; k < LINE_W; k++) begin
      bulk_wdata_o[k*WORD_W +: WORD_W] = mem[PW'(rp_q + PW'(k))];
      bulk_mask_o[k] = (CNT_W'(k) < xfer_n);
    end
  end

  assign busy_o  = active_q;
  assign err_o   = err_q;
  assign line_o  = line_q;
  assign drain_o = !fill;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C);
  p_bulk_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (((fill ? wp_q : rp_q) % PW'(LINE_W)) == '0));
  p_err_while_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(busy_o));
  p_done_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (cnt_q == '0));
endmodule

// File: rtl/sbuf_hub.sv
module sbuf_hub #(
  parameter int unsigned N_WIDE    = 8,
  parameter int unsigned N_NARROW  = 10,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned WIDE_W    = 8,
  parameter int unsigned BUF_DEPTH = 64,
  parameter int unsigned LINE_W    = 32,
  parameter int unsigned ARR_LINES = 64,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RSZ_W     = 4,
  localparam int unsigned N        = N_WIDE + N_NARROW,
  localparam int unsigned AW       = $clog2(ARR_LINES),
  localparam int unsigned WIDE_PW  = WIDE_W * WORD_W,
  localparam int unsigned DW       = N_WIDE * WIDE_PW + N_NARROW * WORD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N-1:0]       start_i,
  input  logic [N-1:0]       dir_i,
  input  logic [N*AW-1:0]    base_i,
  input  logic [N*CNT_W-1:0] rec_cnt_i,
  input  logic [N*RSZ_W-1:0] rec_size_i,
  output logic [N-1:0]       busy_o,
  output logic [N-1:0]       err_o,
  input  logic [N-1:0]       push_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [N-1:0]       wready_o,
  input  logic [N-1:0]       pop_i,
  output logic [DW-1:0]      rdata_o,
  output logic [N-1:0]       rvalid_o,
  output logic [N-1:0]       gnt_o
);
  localparam int unsigned LEN_W = CNT_W + RSZ_W;
  localparam int unsigned LW    = LINE_W * WORD_W;

  logic [N-1:0]        req;
  logic [N-1:0]        drain;
  logic [AW-1:0]       bline [N];
  logic [LW-1:0]       bwd   [N];
  logic [LINE_W-1:0]   bmask [N];
  logic [LW-1:0]       arr_rdata, sel_wd;
  logic [AW-1:0]       sel_line;
  logic [LINE_W-1:0]   sel_mask;
  logic                sel_drain;

  for (genvar c = 0; c < N; c++) begin : g_client
    logic [LEN_W-1:0] len;
    assign len = LEN_W'(rec_cnt_i[c*CNT_W +: CNT_W]) * LEN_W'(rec_size_i[c*RSZ_W +: RSZ_W]);

    if (c < N_WIDE) begin : g_wide
      sba_stream_buf #(
        .WORD_W(WORD_W), .DEPTH(BUF_DEPTH), .LINE_W(LINE_W),
        .CW(WIDE_W), .AW(AW), .LEN_W(LEN_W)
      ) u_buf (
        .clk_i, .rst_ni,
        .start_i(start_i[c]), .dir_i(dir_i[c]), .base_i(base_i[c*AW +: AW]), .len_i(len),
        .busy_o(busy_o[c]), .err_o(err_o[c]),
        .req_o(req[c]), .gnt_i(gnt_o[c]), .line_o(bline[c]), .drain_o(drain[c]),
        .bulk_wdata_o(bwd[c]), .bulk_mask_o(bmask[c]), .bulk_rdata_i(arr_rdata),
        .push_i(push_i[c]), .wdata_i(wdata_i[c*WIDE_PW +: WIDE_PW]), .wready_o(wready_o[c]),
        .pop_i(pop_i[c]), .rdata_o(rdata_o[c*WIDE_PW +: WIDE_PW]), .rvalid_o(rvalid_o[c])
      );
    end else begin : g_narrow
      localparam int unsigned OFS = N_WIDE * WIDE_PW + (c - N_WIDE) * WORD_W;
      sba_stream_buf #(
        .WORD_W(WORD_W), .DEPTH(BUF_DEPTH), .LINE_W(LINE_W),
        .CW(1), .AW(AW), .LEN_W(LEN_W)
      ) u_buf (
        .clk_i, .rst_ni,
        .start_i(start_i[c]), .dir_i(dir_i[c]), .base_i(base_i[c*AW +: AW]), .len_i(len),
        .busy_o(busy_o[c]), .err_o(err_o[c]),
        .req_o(req[c]), .gnt_i(gnt_o[c]), .line_o(bline[c]), .drain_o(drain[c]),
        .bulk_wdata_o(bwd[c]), .bulk_mask_o(bmask[c]), .bulk_rdata_i(arr_rdata),
        .push_i(push_i[c]), .wdata_i(wdata_i[OFS +: WORD_W]), .wready_o(wready_o[c]),
        .pop_i(pop_i[c]), .rdata_o(rdata_o[OFS +: WORD_W]), .rvalid_o(rvalid_o[c])
      );
    end
  end

  sba_rr_arb #(.N(N)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .gnt_o(gnt_o)
  );

  always_comb begin
    sel_line  = '0;
    sel_wd    = '0;
    sel_mask  = '0;
    sel_drain = 1'b0;
    for (int c = 0; c < N; c++) begin
      if (gnt_o[c]) begin
        sel_line  = bline[c];
        sel_wd    = bwd[c];
        sel_mask  = bmask[c];
        sel_drain = drain[c];
      end
    end
  end

  sba_array #(
    .WORD_W(WORD_W), .LINE_W(LINE_W), .LINES(ARR_LINES), .AW(AW)
  ) u_array (
    .clk_i,
    .we_i(sel_drain),
    .addr_i(sel_line),
    .wdata_i(sel_wd),
    .wmask_i(sel_mask),
    .rdata_o(arr_rdata)
  );
endmodule

// File: tb/sbuf_hub_test.sv
module sbuf_hub_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 18;
  localparam int DW = 8*128 + 10*16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]   start = '0, dir = '0, pop_d = '0, push_d = '0, force_pop = '0, force_push = '0;
  logic [N*6-1:0] base_f = '0;
  logic [N*8-1:0] rcnt_f = '0;
  logic [N*4-1:0] rsz_f = '0;
  logic [DW-1:0]  wdata = '0;
  logic [DW-1:0]  rdata;
  logic [N-1:0]   busy, err, wready, rvalid, gnt, pop, push;

  assign pop  = pop_d | force_pop;
  assign push = push_d | force_push;

  sbuf_hub uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir), .base_i(base_f),
    .rec_cnt_i(rcnt_f), .rec_size_i(rsz_f), .busy_o(busy), .err_o(err),
    .push_i(push), .wdata_i(wdata), .wready_o(wready),
    .pop_i(pop), .rdata_o(rdata), .rvalid_o(rvalid), .gnt_o(gnt)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] mdl [2048];
  bit    bs_on [N], bs_dir [N], bs_hold [N], chk_low [N];
  int    bs_len [N], bs_idx [N], bs_base [N];
  string rd_tag [N];
  bit    fair_on = 0;
  int    fair_n = 0;
  logic [N-1:0] fair_mask = '0;
  logic [15:0] dv;

  function automatic int cw(int c); return (c < 8) ? 8 : 1; endfunction
  function automatic int ofs(int c); return (c < 8) ? c*128 : 1024 + (c-8)*16; endfunction
  function automatic bit any_on();
    for (int c = 0; c < N; c++) if (bs_on[c]) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // client model: random pops/pushes, data compared against the array model
  always @(negedge clk) begin
    for (int c = 0; c < N; c++) begin
      if (chk_low[c]) begin
        chk(busy[c] == 1'b0, "R9 busy after last pop", int'(busy[c]), 0);
        chk_low[c] = 0;
      end
      pop_d[c]  = 1'b0;
      push_d[c] = 1'b0;
      if (bs_on[c] && !bs_hold[c]) begin
        if (!bs_dir[c] && rvalid[c] && ($urandom % 4 != 0)) begin
          for (int k = 0; k < cw(c); k++) begin
            dv = rdata[ofs(c) + k*16 +: 16];
            chk(dv == mdl[(bs_base[c]*32 + bs_idx[c] + k) % 2048], rd_tag[c], int'(dv),
                int'(mdl[(bs_base[c]*32 + bs_idx[c] + k) % 2048]));
          end
          pop_d[c] = 1'b1;
          bs_idx[c] += cw(c);
          if (bs_idx[c] == bs_len[c]) begin bs_on[c] = 0; chk_low[c] = 1; end
        end else if (bs_dir[c] && wready[c] && ($urandom % 4 != 0)) begin
          for (int k = 0; k < cw(c); k++) begin
            dv = 16'($urandom);
            wdata[ofs(c) + k*16 +: 16] = dv;
            mdl[(bs_base[c]*32 + bs_idx[c] + k) % 2048] = dv;
          end
          push_d[c] = 1'b1;
          bs_idx[c] += cw(c);
          if (bs_idx[c] == bs_len[c]) bs_on[c] = 0;
        end
      end
    end
    if (fair_on && gnt != '0) begin
      chk($onehot(gnt), "R6 one grant", int'(gnt), 0);
      fair_mask |= gnt;
      fair_n++;
      if (fair_n == N) begin
        chk(fair_mask == '1, "R6 round-robin cover", int'(fair_mask), int'({N{1'b1}}));
        fair_on = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic set_desc(int c, bit d, int b, int cnt, int sz, bit track);
    dir[c] = d;
    base_f[c*6 +: 6] = 6'(b);
    rcnt_f[c*8 +: 8] = 8'(cnt);
    rsz_f[c*4 +: 4]  = 4'(sz);
    start[c] = 1'b1;
    if (track) begin
      bs_dir[c] = d; bs_base[c] = b; bs_len[c] = cnt*sz; bs_idx[c] = 0; bs_on[c] = 1;
    end
  endtask

  task automatic pulse();
    @(posedge clk);
    @(negedge clk);
    start = '0;
  endtask

  task automatic one(int c, bit d, int b, int cnt, int sz, string tag);
    rd_tag[c] = tag;
    set_desc(c, d, b, cnt, sz, 1);
    pulse();
    chk(busy[c] == 1'b1, "R1 busy after start", int'(busy[c]), 1);
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (any_on() || (|busy));
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < N; c++) begin
      bs_on[c] = 0; bs_hold[c] = 0; chk_low[c] = 0; rd_tag[c] = "R2";
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy == '0 && rvalid == '0 && wready == '0 && err == '0 && gnt == '0,
        "R9 reset", int'(busy | rvalid | wready | gnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: wide drain, read back by a narrow client
    one(0, 1, 0, 8, 8, "R4");
    wait_idle();
    one(10, 0, 0, 16, 4, "R4");
    wait_idle();

    // R5: 40-word drain ends mid-line; rest of line 1 must survive
    one(11, 1, 0, 8, 5, "R5");
    wait_idle();
    one(3, 0, 0, 8, 8, "R5 trailing mask");
    wait_idle();

    // R3: long stall on a narrow fill
    one(1, 1, 2, 16, 8, "R4");
    wait_idle();
    bs_hold[12] = 1;
    one(12, 0, 2, 128, 1, "R3 stalled fill");
    repeat (60) @(negedge clk);
    bs_hold[12] = 0;
    wait_idle();

    // R7: pop before first line lands
    bs_hold[13] = 1;
    one(13, 0, 2, 32, 1, "R7 early pop");
    chk(rvalid[13] == 1'b0, "R7 no data yet", int'(rvalid[13]), 0);
    force_pop[13] = 1'b1;
    @(negedge clk);
    force_pop[13] = 1'b0;
    bs_hold[13] = 0;
    wait_idle();
    // R7: push while idle is dropped
    chk(wready[14] == 1'b0, "R7 no room when idle", int'(wready[14]), 0);
    force_push[14] = 1'b1;
    @(negedge clk);
    force_push[14] = 1'b0;
    one(14, 1, 8, 64, 1, "R7");
    wait_idle();
    one(5, 0, 8, 8, 8, "R7 readback");
    wait_idle();

    // R8: mid-stream restarts
    bs_hold[9] = 1;
    one(9, 1, 10, 64, 1, "R8");
    set_desc(9, 0, 20, 4, 4, 0);
    pulse();
    chk(err[9] == 1'b1, "R8 err on direction change", int'(err[9]), 1);
    @(negedge clk);
    chk(err[9] == 1'b0, "R8 err one cycle", int'(err[9]), 0);
    set_desc(9, 1, 20, 4, 4, 0);
    pulse();
    chk(err[9] == 1'b0, "R8 same dir no err", int'(err[9]), 0);
    chk(busy[9] == 1'b1, "R8 stream kept", int'(busy[9]), 1);
    bs_hold[9] = 0;
    wait_idle();
    one(15, 0, 10, 64, 1, "R8 original base");
    wait_idle();

    // R2/R6: random concurrent rounds on disjoint regions
    for (int r = 0; r < 4; r++) begin
      for (int c = 0; c < N; c++) begin
        automatic int sz  = (c < 8) ? 8 : 1 + int'($urandom % 6);
        automatic int cnt = 1 + int'($urandom % (96 / sz));
        set_desc(c, 1, c*3, cnt, sz, 1);
      end
      pulse();
      wait_idle();
      for (int c = 0; c < N; c++) begin
        rd_tag[c] = "R2";
        set_desc(c, 0, bs_base[c], bs_len[c] / ((c < 8) ? 8 : 1), (c < 8) ? 8 : 1, 1);
      end
      fair_mask = '0;
      fair_n = 0;
      fair_on = 1;
      pulse();
      wait_idle();
      chk(fair_on == 0, "R6 fairness window seen", int'(fair_on), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule